// File: doc/BRIEF.md
# Legacy Interrupt Line Status and Mask Register

This block collects the four legacy level-sensitive interrupt lines of a PCI bridge (INTA, INTB, INTC, INTD) into one 32-bit control register. Each line first passes through a synchronizer. Its status bit is then set on any cycle where the synchronized line is high. The bit stays set until software acknowledges it by writing a one to that bit. A per-line enable bit gates the status. The gated bits are ORed together and registered to form a single interrupt request toward a parent interrupt controller.

The same register also holds plain storage fields. These are enable bits for several bus-error interrupt sources, one master priority flag per requester, and a small target-ready wait value. Software reaches the register through a simple write port with byte strobes and a continuously driven read port. Reads have no side effects. A write must use write-one-to-clear for the status bits and plain write for every other field, because both kinds share the same word. A halfword write of 0xF000 to the upper half clears all status bits and all enable bits in one access.

Top module: `intx_irq_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00000000 and `irq_out` is low.
- R2: A line held high sets its status bit (bit 28 for INTA up to bit 31 for INTD) on the third rising edge after the line changes, with the default two synchronizer stages. The bit stays set after the line returns low.
- R3: A write with `reg_wstrb[3]` high and a one in a status bit clears that bit if its line is low. A zero written to a status bit leaves it unchanged.
- R4: If a line is still high in the cycle of its acknowledge, the status bit stays set.
- R5: Bits 25:22 are per-line enable bits, with INTA at bit 22 and INTD at bit 25. They are written directly and read back as written. A 1 lets the line interrupt and a 0 blocks it.
- R6: `irq_out` goes high one clock after any status bit and its enable bit are both set. It goes low one clock after no such pair remains.
- R7: Bits 27:26 and 21:16 (error interrupt enables), bits 14:8 (priority flags for requesters 0 to 6) and bits 3:0 (wait value) are plain read/write storage. They have no effect on `irq_out`.
- R8: Bits 15 and 7:4 read as zero whatever is written to them.
- R9: Only bytes whose strobe is high are affected by a write (byte n covers bits 8n+7:8n). A write of 0xF0000000 with strobes 4'b1100 clears all status bits whose lines are low and all bits 27:16, and leaves bits 15:0 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| intx_in | input | 4 | Asynchronous interrupt lines, bit 0 = INTA |
| reg_wr | input | 1 | Register write strobe |
| reg_wstrb | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current register contents |
| irq_out | output | 1 | Combined registered interrupt request |

## Verification
The hardest case to reach is an acknowledge that lands in the exact cycle when the synchronized line is still high. This needs the write to be lined up with the synchronizer delay. A directed test holds one line high across the acknowledge so that the overlap is certain. The random phase toggles lines and issues writes with random strobes on the same cycles, and a bench model predicts the outcome, so partial overlaps on several lines also occur. Directed halfword clears and all-ones writes cover the strobe and reserved-bit rules.

// File: rtl/intx_pkg.sv
package intx_pkg;
   localparam int REG_W      = 32;
   localparam int LINES      = 4;
   localparam int STAT_LSB   = 28;
   localparam int MASK_LSB   = 22;
   localparam int STAT_BYTE  = STAT_LSB / 8;
   localparam int BYTES      = REG_W / 8;
   // plain read/write storage: 27:16, 14:8, 3:0
   localparam logic [REG_W-1:0] RW_BITS = 32'h0FFF_7F0F;
endpackage

// File: rtl/intx_sync.sv
module intx_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("intx_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n)      chain[s] <= '0;
         else if (s == 0) chain[s] <= d_in;
         else             chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign d_out = chain[STAGES-1];
endmodule

// File: rtl/intx_line.sv
module intx_line (
   input  logic clk,
   input  logic rst_n,
   input  logic line_sync,
   input  logic ack,
   input  logic enable,
   output logic status,
   output logic pend
);
   always_ff @(posedge clk) begin
      if (!rst_n) status <= 1'b0;
      else        status <= line_sync | (status & ~ack);
   end

   assign pend = status & enable;

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      status && !ack |=> status);
   assert_input_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      line_sync |=> status);
   assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      status && ack && !line_sync |=> !status);
endmodule

// File: rtl/intx_store.sv
module intx_store
   import intx_pkg::*;
#(
   parameter int               WIDTH = REG_W,
   parameter logic [WIDTH-1:0] KEEP  = RW_BITS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [WIDTH/8-1:0] wstrb,
   input  logic [WIDTH-1:0]   wdata,
   output logic [WIDTH-1:0]   q
);
   if (WIDTH % 8 != 0) begin : g_bad_width
      $error("intx_store: WIDTH must be a multiple of 8");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      if (KEEP[b]) begin : g_rw
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                bit_q <= 1'b0;
            else if (wr && wstrb[b/8]) bit_q <= wdata[b];
         end
         assign q[b] = bit_q;
      end else begin : g_zero
         assign q[b] = 1'b0;
      end
   end

   assert_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(q));
endmodule

// File: rtl/intx_irq_ctrl.sv
module intx_irq_ctrl
   import intx_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] intx_in,
   input  logic             reg_wr,
   input  logic [BYTES-1:0] reg_wstrb,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             irq_out
);
   if (STAT_LSB + LINES > REG_W || MASK_LSB + LINES > STAT_LSB) begin : g_bad_map
      $error("intx_irq_ctrl: field layout does not fit");
   end

   logic [LINES-1:0] line_sync;
   logic [LINES-1:0] status;
   logic [LINES-1:0] pend;
   logic [LINES-1:0] ack;
   logic [REG_W-1:0] store_q;

   intx_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d_in(intx_in), .d_out(line_sync));

   intx_store #(.WIDTH(REG_W), .KEEP(RW_BITS)) i_store (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wstrb(reg_wstrb),
      .wdata(reg_wdata), .q(store_q));

   for (genvar i = 0; i < LINES; i++) begin : g_line
      assign ack[i] = reg_wr & reg_wstrb[STAT_BYTE] & reg_wdata[STAT_LSB+i];
      intx_line i_line (
         .clk(clk), .rst_n(rst_n), .line_sync(line_sync[i]), .ack(ack[i]),
         .enable(store_q[MASK_LSB+i]), .status(status[i]), .pend(pend[i]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq_out <= 1'b0;
      else        irq_out <= |pend;
   end

   always_comb begin
      reg_rdata = store_q;
      reg_rdata[STAT_LSB +: LINES] = status;
   end

   assert_irq_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(status & reg_rdata[MASK_LSB +: LINES])) |=> irq_out);
   assert_irq_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(status & reg_rdata[MASK_LSB +: LINES])) |=> !irq_out);
endmodule

// File: tb/test_intx_irq_ctrl.sv
module test_intx_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  intx_in = '0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_wstrb = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_out;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   intx_irq_ctrl i_intx_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .intx_in(intx_in), .reg_wr(reg_wr),
      .reg_wstrb(reg_wstrb), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_out(irq_out));

   // requirement-level model
   localparam logic [31:0] RW = 32'h0FFF_7F0F;
   logic [3:0]  m_s1, m_s2, m_stat;
   logic [31:0] m_store;
   logic        m_irq;

   function automatic logic [31:0] merge(logic [31:0] old, logic [3:0] st, logic [31:0] d);
      logic [31:0] r = old;
      for (int b = 0; b < 32; b++)
         if (RW[b] && st[b/8]) r[b] = d[b];
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_stat <= '0; m_store <= '0; m_irq <= 1'b0;
      end else begin
         m_s1 <= intx_in;
         m_s2 <= m_s1;
         m_stat <= m_s2 | (m_stat & ~((reg_wr && reg_wstrb[3]) ? reg_wdata[31:28] : 4'h0));
         if (reg_wr) m_store <= merge(m_store, reg_wstrb, reg_wdata);
         m_irq <= |(m_stat & m_store[25:22]);
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] st, logic [31:0] d);
      reg_wr = 1'b1; reg_wstrb = st; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wstrb = '0; reg_wdata = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      void'($urandom(32'h1234_5678));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rdata reset", reg_rdata, 32'h0);
      chk("R1 irq reset", {31'h0, irq_out}, 32'h0);

      // R7 R8: all ones, full strobes; lines low so status stays clear
      wr(4'hF, 32'hFFFF_FFFF);
      chk("R7 R8 all ones", reg_rdata, 32'h0FFF_7F0F);
      chk("R7 irq unaffected by storage", {31'h0, irq_out}, 32'h0);
      wr(4'hF, 32'h0A5A_3C05);
      chk("R7 pattern", reg_rdata, 32'h0A5A_3C05 & RW);

      // R5: enable only INTA (bit 22), clear the rest
      wr(4'hF, 32'h0040_0000);
      chk("R5 enable INTA", reg_rdata, 32'h0040_0000);

      // R2 R6: INTA rises
      intx_in = 4'b0001;
      repeat (2) @(negedge clk);
      chk("R2 not yet set", reg_rdata, 32'h0040_0000);
      @(negedge clk);
      chk("R2 set on third edge", reg_rdata, 32'h1040_0000);
      chk("R6 irq one cycle later", {31'h0, irq_out}, 32'h0);
      @(negedge clk);
      chk("R6 irq high", {31'h0, irq_out}, 32'h1);
      intx_in = 4'b0000;
      repeat (4) @(negedge clk);
      chk("R2 sticky", reg_rdata, 32'h1040_0000);

      // R3: zero leaves; strobe low leaves; one clears
      wr(4'hF, 32'h0040_0000);
      chk("R3 zero keeps", reg_rdata, 32'h1040_0000);
      wr(4'h7, 32'hF040_0000);
      chk("R9 strobe off keeps status", reg_rdata, 32'h1040_0000);
      wr(4'h8, 32'h1000_0000);
      chk("R3 ack clears", reg_rdata, 32'h0040_0000);
      chk("R6 irq still high one cycle", {31'h0, irq_out}, 32'h1);
      @(negedge clk);
      chk("R6 irq falls", {31'h0, irq_out}, 32'h0);

      // R5: masked line sets status but no irq
      intx_in = 4'b0100;
      repeat (5) @(negedge clk);
      chk("R5 masked status", reg_rdata, 32'h4040_0000);
      chk("R5 masked no irq", {31'h0, irq_out}, 32'h0);
      wr(4'h4, 32'h0010_0000);
      chk("R5 enable INTC bit 24 not in byte 2", reg_rdata, 32'h4010_0000);
      wr(4'h8, 32'h0100_0000);
      @(negedge clk);
      chk("R5 INTC enabled irq", {31'h0, irq_out}, 32'h1);

      // R4: ack while line still high
      wr(4'h8, 32'h4100_0000);
      chk("R4 input wins", reg_rdata[31:28], 32'h4);
      intx_in = 4'b0000;
      repeat (3) @(negedge clk);
      wr(4'h8, 32'h4100_0000);
      chk("R4 clears once low", reg_rdata, 32'h0110_0000);

      // R9: halfword 0xF000 to upper half
      wr(4'hF, 32'h0FFF_7F0F);
      intx_in = 4'b1010;
      repeat (4) @(negedge clk);
      intx_in = 4'b0000;
      repeat (3) @(negedge clk);
      chk("R9 before clear", reg_rdata, 32'hAFFF_7F0F);
      wr(4'hC, 32'hF000_0000);
      chk("R9 halfword clear", reg_rdata, 32'h0000_7F0F);
      @(negedge clk);
      chk("R9 irq off", {31'h0, irq_out}, 32'h0);

      // random phase against the model
      for (int n = 0; n < 3000; n++) begin
         chk("R2 R3 R4 R5 R6 R7 R9 random rdata", reg_rdata,
             m_store | {m_stat, 28'h0});
         chk("R6 random irq", {31'h0, irq_out}, {31'h0, m_irq});
         if ($urandom_range(0, 3) == 0) intx_in = 4'($urandom);
         if ($urandom_range(0, 2) == 0) begin
            reg_wr = 1'b1; reg_wstrb = 4'($urandom); reg_wdata = $urandom;
         end else begin
            reg_wr = 1'b0; reg_wstrb = '0; reg_wdata = '0;
         end
         @(negedge clk);
      end
      reg_wr = 1'b0;
      finish_run();
   end
endmodule